// File: doc/BRIEF.md
# UART Interrupt Arbiter and Modem Status Unit

This unit sits between the serial engines of a UART and its register file. It merges four interrupt causes (receiver line error, receive data available, transmit holding register empty and modem line change) into a single interrupt request. It reports the cause with the highest priority as a small identification code. The interrupt pin has a separate output enable, so that the pad can be tristated.

The unit also keeps the modem status byte. The four active-low modem input pins pass through a synchronizer and are shown active-high in the upper nibble. The lower nibble holds sticky change flags, which clear when the status byte is read. In loopback the four modem control bits take the place of the pins, and the transmit line is held at mark.

There is no data stream through this block. Every port is a plain level or a single-cycle strobe, so no valid/ready handshake applies. Read and write strobes are asserted for one clock and take effect at that clock edge.

Top module: `irq_modem_unit`

## Requirements
- R1: Mask bit 0 enables receive-ready, bit 1 transmit-empty, bit 2 line-status and bit 3 modem-status. A source whose mask bit is 0 never signals. With no enabled source pending, `id_byte` reads 8'h01 and `irq_out` is 0.
- R2: The priority code is placed in `id_byte[2:1]`. The order, highest first, is line status (2'b11), receive ready (2'b10), transmit empty (2'b01) and modem status (2'b00). `id_byte[0]` is 0 while any enabled source is pending. Bits 7:3 are 0. `irq_out` is high exactly when a source is pending.
- R3: Outside loopback, `msr_byte[4]`, `[5]`, `[6]` and `[7]` are the complements of `cts_n`, `dsr_n`, `ri_n` and `dcd_n`. A pin change appears there after two clock edges.
- R4: Change flags are held in `msr_byte[0]` (CTS), `[1]` (DSR) and `[3]` (CD). Each sets on any change of its line, three edges after a pin change. The RI flag `msr_byte[2]` sets only when `ri_n` goes from low to high.
- R5: A pulse on `msr_rd` clears all four change flags at that edge. Any set change flag is the modem-status interrupt source.
- R6: The transmit-empty source sets in two cases: when `thr_empty` rises, or when mask bit 1 goes from 0 to 1 while `thr_empty` is high. It clears on `thr_wr`. It also clears on `id_rd` while code 2'b01 is the reported one. An `id_rd` while another code is reported leaves it set.
- R7: With `mcr_loop` high, `msr_byte[7:4]` equals {`mcr_out2`, `mcr_out1`, `mcr_dtr`, `mcr_rts`} and the pins are ignored. Changes of these bits set change flags one edge later, and `tx_mark` is high.
- R8: `irq_oe` equals `mcr_out2`; when it is 0 the interrupt pin is tristated.
- R9: After reset, `id_byte` is 8'h01, the change flags are 0 and no transmit-empty source is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_mask | input | 4 | Interrupt enable mask |
| line_err | input | 1 | Receiver line error condition (level) |
| rx_avail | input | 1 | Received data available (level) |
| thr_empty | input | 1 | Transmit holding register empty (level) |
| id_rd | input | 1 | Read strobe of the identification register |
| msr_rd | input | 1 | Read strobe of the modem status byte |
| thr_wr | input | 1 | Write strobe of the transmit holding register |
| cts_n | input | 1 | Clear-to-send pin, active low |
| dsr_n | input | 1 | Data-set-ready pin, active low |
| ri_n | input | 1 | Ring indicator pin, active low |
| dcd_n | input | 1 | Carrier detect pin, active low |
| mcr_dtr | input | 1 | Data-terminal-ready control bit |
| mcr_rts | input | 1 | Request-to-send control bit |
| mcr_out1 | input | 1 | User output 1 control bit |
| mcr_out2 | input | 1 | User output 2, interrupt pin enable |
| mcr_loop | input | 1 | Loopback enable |
| id_byte | output | 8 | Interrupt identification byte |
| msr_byte | output | 8 | Modem status byte |
| irq_out | output | 1 | Interrupt request |
| irq_oe | output | 1 | Output enable of the interrupt pin |
| tx_mark | output | 1 | Hold the transmit line at mark |

## Verification
`id_byte` and `irq_out` follow the level sources and the mask in the same cycle. They follow strobes, the transmit-empty edge and change flags one edge later. The modem status levels follow a pin after two edges and a loopback control bit at once; their change flags need one more edge. The bench drives every input just after a rising edge and counts the edges to the due cycle before it samples. Where a result must not yet have moved, it also samples one edge early.

// File: rtl/irq_modem_pkg.sv
package irq_modem_pkg;
  localparam int NUM_SRC = 4;
  localparam int NUM_LINES = 4;

  // mask bit positions
  localparam int MSK_RX = 0;
  localparam int MSK_TX = 1;
  localparam int MSK_LS = 2;
  localparam int MSK_MS = 3;

  // modem line order inside the status nibble
  localparam int LN_CTS = 0;
  localparam int LN_DSR = 1;
  localparam int LN_RI  = 2;
  localparam int LN_CD  = 3;

  typedef enum logic [1:0] {
    ID_MODEM = 2'b00,
    ID_THR   = 2'b01,
    ID_RXRDY = 2'b10,
    ID_LINE  = 2'b11
  } irq_id_e;

  function automatic irq_id_e code_of(input int src);
    case (src)
      MSK_LS:  return ID_LINE;
      MSK_RX:  return ID_RXRDY;
      MSK_TX:  return ID_THR;
      default: return ID_MODEM;
    endcase
  endfunction
endpackage

// File: rtl/modem_pin_sync.sv
module modem_pin_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pins_n,
  output logic [WIDTH-1:0] pins_sync_n
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '1;
        else        stg[s] <= pins_n;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '1;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign pins_sync_n = stg[STAGES-1];
endmodule

// File: rtl/modem_status_reg.sv
module modem_status_reg
  import irq_modem_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] pins_sync_n,
  input  logic                 loop_en,
  input  logic [NUM_LINES-1:0] loop_lvl,
  input  logic                 msr_rd,
  output logic [7:0]           msr_o,
  output logic                 change_any
);
  logic [NUM_LINES-1:0] lvl, lvl_q, set_vec, delta;

  assign lvl = loop_en ? loop_lvl : ~pins_sync_n;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_set
    if (i == LN_RI) begin : g_ring
      // ring flag only on release of the ring line
      assign set_vec[i] = lvl_q[i] & ~lvl[i];
    end else begin : g_any
      assign set_vec[i] = lvl_q[i] ^ lvl[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      delta <= '0;
    end else begin
      lvl_q <= lvl;
      delta <= (msr_rd ? '0 : delta) | set_vec;
    end
  end

  assign msr_o      = {lvl, delta};
  assign change_any = |delta;

  AST_DELTA_CLEARED_BY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (msr_rd && set_vec == '0) |=> (delta == '0)); // R5

  AST_RI_NO_SET_ON_ASSERT: assert property (@(posedge clk) disable iff (!rst_n)
    (!delta[LN_RI] && !msr_rd && !lvl_q[LN_RI]) |=> !delta[LN_RI]); // R4

  AST_DELTA_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!msr_rd && change_any) |=> change_any); // R5
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_modem_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] mask,
  input  logic               line_err,
  input  logic               rx_avail,
  input  logic               thr_empty,
  input  logic               modem_evt,
  input  logic               id_rd,
  input  logic               thr_wr,
  output logic [7:0]         id_byte,
  output logic               irq_req
);
  // scan order, highest priority first
  localparam int RANK [NUM_SRC] = '{MSK_LS, MSK_RX, MSK_TX, MSK_MS};

  logic               thr_pend, thr_empty_q, mask_tx_q;
  logic               thr_set, thr_clr;
  logic [NUM_SRC-1:0] src_raw, src_en;
  irq_id_e            code;

  assign thr_set = thr_empty & (~thr_empty_q | (mask[MSK_TX] & ~mask_tx_q));
  assign thr_clr = thr_wr | (id_rd & irq_req & (code == ID_THR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_pend    <= 1'b0;
      thr_empty_q <= 1'b1;
      mask_tx_q   <= 1'b0;
    end else begin
      thr_empty_q <= thr_empty;
      mask_tx_q   <= mask[MSK_TX];
      if (thr_set)      thr_pend <= 1'b1;
      else if (thr_clr) thr_pend <= 1'b0;
    end
  end

  always_comb begin
    src_raw         = '0;
    src_raw[MSK_RX] = rx_avail;
    src_raw[MSK_TX] = thr_pend;
    src_raw[MSK_LS] = line_err;
    src_raw[MSK_MS] = modem_evt;
  end

  assign src_en  = src_raw & mask;
  assign irq_req = |src_en;

  always_comb begin
    code = ID_MODEM;
    for (int k = NUM_SRC - 1; k >= 0; k--) begin
      if (src_en[RANK[k]]) code = code_of(RANK[k]);
    end
  end

  assign id_byte = {5'b0, code, ~irq_req};

  AST_LINE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (line_err && mask[MSK_LS]) |-> (id_byte[2:0] == 3'b110)); // R2

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> (id_byte == 8'h01 && !irq_req)); // R1

  AST_THR_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr && !thr_set) |=> !thr_pend); // R6

  AST_THR_KEPT_OTHER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_pend && id_rd && !thr_wr && id_byte[2:1] != 2'b01) |=> thr_pend); // R6
endmodule

// File: rtl/irq_modem_unit.sv
module irq_modem_unit
  import irq_modem_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] irq_mask,
  input  logic       line_err,
  input  logic       rx_avail,
  input  logic       thr_empty,
  input  logic       id_rd,
  input  logic       msr_rd,
  input  logic       thr_wr,
  input  logic       cts_n,
  input  logic       dsr_n,
  input  logic       ri_n,
  input  logic       dcd_n,
  input  logic       mcr_dtr,
  input  logic       mcr_rts,
  input  logic       mcr_out1,
  input  logic       mcr_out2,
  input  logic       mcr_loop,
  output logic [7:0] id_byte,
  output logic [7:0] msr_byte,
  output logic       irq_out,
  output logic       irq_oe,
  output logic       tx_mark
);
  logic [NUM_LINES-1:0] pins_n, pins_sync_n, loop_lvl;
  logic                 change_any;

  always_comb begin
    pins_n         = '1;
    pins_n[LN_CTS] = cts_n;
    pins_n[LN_DSR] = dsr_n;
    pins_n[LN_RI]  = ri_n;
    pins_n[LN_CD]  = dcd_n;
    loop_lvl         = '0;
    loop_lvl[LN_CTS] = mcr_rts;
    loop_lvl[LN_DSR] = mcr_dtr;
    loop_lvl[LN_RI]  = mcr_out1;
    loop_lvl[LN_CD]  = mcr_out2;
  end

  modem_pin_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) i_sync (
    .clk         (clk),
    .rst_n       (rst_n),
    .pins_n      (pins_n),
    .pins_sync_n (pins_sync_n)
  );

  modem_status_reg i_msr (
    .clk         (clk),
    .rst_n       (rst_n),
    .pins_sync_n (pins_sync_n),
    .loop_en     (mcr_loop),
    .loop_lvl    (loop_lvl),
    .msr_rd      (msr_rd),
    .msr_o       (msr_byte),
    .change_any  (change_any)
  );

  irq_arbiter i_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .mask      (irq_mask),
    .line_err  (line_err),
    .rx_avail  (rx_avail),
    .thr_empty (thr_empty),
    .modem_evt (change_any),
    .id_rd     (id_rd),
    .thr_wr    (thr_wr),
    .id_byte   (id_byte),
    .irq_req   (irq_out)
  );

  assign irq_oe  = mcr_out2;
  assign tx_mark = mcr_loop;

  AST_LOOP_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    mcr_loop |-> (msr_byte[7:4] == {mcr_out2, mcr_out1, mcr_dtr, mcr_rts})); // R7

  AST_MODEM_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mask == 4'b1000 && msr_byte[3:0] != 4'h0) |-> (irq_out && id_byte == 8'h00)); // R5
endmodule

// File: tb/test_irq_modem_unit.sv
module test_irq_modem_unit;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 20000;
  localparam int  NVEC       = 10;
  // [15:12] mask, [11] line_err, [10] rx_avail, [7:0] expected id
  localparam logic [15:0] VEC [NVEC] = '{
    16'hFC06, 16'hF404, 16'hF002, 16'h7002, 16'h8000,
    16'h0C01, 16'hBC04, 16'hE402, 16'h9000, 16'h4401
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] irq_mask = '0;
  logic line_err = 0, rx_avail = 0, thr_empty = 0, id_rd = 0, msr_rd = 0, thr_wr = 0;
  logic cts_n = 1, dsr_n = 1, ri_n = 1, dcd_n = 1;
  logic mcr_dtr = 0, mcr_rts = 0, mcr_out1 = 0, mcr_out2 = 0, mcr_loop = 0;
  logic [7:0] id_byte, msr_byte;
  logic irq_out, irq_oe, tx_mark;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_modem_unit i_irq_modem_unit (
    .clk(clk), .rst_n(rst_n), .irq_mask(irq_mask), .line_err(line_err),
    .rx_avail(rx_avail), .thr_empty(thr_empty), .id_rd(id_rd), .msr_rd(msr_rd),
    .thr_wr(thr_wr), .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .dcd_n(dcd_n),
    .mcr_dtr(mcr_dtr), .mcr_rts(mcr_rts), .mcr_out1(mcr_out1), .mcr_out2(mcr_out2),
    .mcr_loop(mcr_loop), .id_byte(id_byte), .msr_byte(msr_byte),
    .irq_out(irq_out), .irq_oe(irq_oe), .tx_mark(tx_mark)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic pulse_msr_rd();
    msr_rd = 1; tick(1); msr_rd = 0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    chk("R9 id after reset", id_byte, 8'h01);
    chk("R9 msr after reset", msr_byte, 8'h00);
    chk("R8 oe after reset", {7'b0, irq_oe}, 8'h00);

    // modem change flag on CTS and transmit-empty edge
    cts_n = 0;
    tick(2);
    chk("R3 cts level after two edges", msr_byte, 8'h10);
    tick(1);
    chk("R4 cts flag after three edges", msr_byte, 8'h11);
    thr_empty = 1;
    tick(1);

    // R1 R2 priority table
    for (int v = 0; v < NVEC; v++) begin
      irq_mask = VEC[v][15:12];
      line_err = VEC[v][11];
      rx_avail = VEC[v][10];
      #1;
      chk("R2 priority table", id_byte, VEC[v][7:0]);
      chk("R1 irq pin vs table", {7'b0, irq_out}, {7'b0, ~VEC[v][0]});
      tick(1);
    end

    // R6 id read clears transmit-empty only when it is reported
    irq_mask = 4'hF; line_err = 0; rx_avail = 1; #1;
    chk("R2 rx reported", id_byte, 8'h04);
    id_rd = 1; tick(1); id_rd = 0;
    rx_avail = 0; #1;
    chk("R6 tx kept after other read", id_byte, 8'h02);
    id_rd = 1; tick(1); id_rd = 0;
    chk("R6 tx cleared by id read", id_byte, 8'h00);
    pulse_msr_rd();
    chk("R5 flags cleared by read", msr_byte, 8'h10);
    chk("R5 no modem irq after read", id_byte, 8'h01);

    // R6 write clears, mask rise sets
    thr_empty = 0; tick(1); thr_empty = 1; tick(1);
    chk("R6 tx set on empty rise", id_byte, 8'h02);
    thr_wr = 1; tick(1); thr_wr = 0;
    chk("R6 tx cleared by write", id_byte, 8'h01);
    irq_mask = 4'h0; tick(1);
    irq_mask = 4'h2; tick(1);
    chk("R6 tx set on mask rise", id_byte, 8'h02);
    thr_wr = 1; tick(1); thr_wr = 0;
    irq_mask = 4'hF; #1;
    chk("R6 tx cleared again", id_byte, 8'h01);

    // R4 ring indicator flag only on release
    ri_n = 0;
    tick(1);
    chk("R3 ri not yet visible", msr_byte, 8'h10);
    tick(2);
    chk("R4 no ri flag on assert", msr_byte, 8'h50);
    ri_n = 1;
    tick(3);
    chk("R4 ri flag on release", msr_byte, 8'h14);
    chk("R5 modem irq from ri flag", id_byte, 8'h00);
    pulse_msr_rd();
    dsr_n = 0; tick(3);
    chk("R4 dsr flag", msr_byte, 8'h32);
    pulse_msr_rd();
    dcd_n = 0; tick(3);
    chk("R4 cd flag", msr_byte, 8'hB8);
    pulse_msr_rd();
    chk("R5 cleared after cd", msr_byte, 8'hB0);

    // R8 tristate control
    rx_avail = 1; #1;
    chk("R8 irq high while oe low", {6'b0, irq_out, irq_oe}, 8'h02);
    mcr_out2 = 1; #1;
    chk("R8 oe follows out2", {7'b0, irq_oe}, 8'h01);
    rx_avail = 0;

    // R7 loopback
    mcr_rts = 1; mcr_dtr = 0; mcr_out1 = 1; mcr_loop = 1; #1;
    chk("R7 loop status immediate", msr_byte, 8'hD0);
    chk("R7 tx held at mark", {7'b0, tx_mark}, 8'h01);
    tick(1);
    chk("R7 loop change flag", msr_byte, 8'hD2);
    cts_n = 1; dcd_n = 1;
    tick(4);
    chk("R7 pins ignored in loop", msr_byte, 8'hD2);
    pulse_msr_rd();
    chk("R7 cleared in loop", msr_byte, 8'hD0);
    mcr_out1 = 0; tick(1);
    chk("R7 ring release from out1", msr_byte, 8'h94);
    chk("R5 modem irq in loop", id_byte, 8'h00);
    mcr_loop = 0; tick(1);
    chk("R7 leave loop back to pins", msr_byte, 8'h2F);
    chk("R7 mark released", {7'b0, tx_mark}, 8'h00);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule